// File: doc/BRIEF.md
# Processor Processing-State Controller

This block is the supervisory state machine that records which processing state a CPU core occupies: held in reset, handling an exception, released to an external bus master, executing the program, or in one of three power-down modes. It reacts to a reset pin, the NMI level, interrupt and DMA address-error events, an end-of-exception strobe, a bus request, a SLEEP-instruction strobe and a standby-select bit. It drives a bus grant, a core clock enable and one clock enable per peripheral module. The pipeline, the vector fetch and the clock generator are outside the block. They take the state and the enables from it.

A low reset pin wins over every other input. The reset flavour is latched from the NMI level while the pin is low: NMI high gives a power-on reset and NMI low gives a manual reset. Power-down has four forms. Sleep stops the core but keeps the clock running. Standby stops the clock until NMI arrives. A clock pause holds the clock only while a pause request is present. Module standby gates single peripheral clocks, one stop bit each, and leaves the CPU state unchanged.

Top module: `pstate_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `state_code` becomes 0 (reset) after that edge, whatever the other inputs and the current state are.
- R2: `manual_rst` takes the inverse of `nmi_lvl` at every edge where `rst_n` is low and keeps its value otherwise. 1 means manual reset and 0 means power-on reset.
- R3: In state 0 with `rst_n` high, the next state is 1 (exception handling).
- R4: In state 3 (program execution), `irq_evt` or `dma_err_evt` moves the machine to state 1. In state 1, `exc_done` moves it to state 3.
- R5: `bus_req` in state 1 or state 3 moves the machine to state 2 (bus released). This takes priority over any other event in the same cycle. When `bus_req` drops, the machine returns to the state it left. `bus_grant` is high exactly in state 2.
- R6: In state 3, with no bus request and no interrupt, DMA error or NMI event, `sleep_cmd` enters state 4 (sleep) when `stby_sel` is 0 and state 5 (standby) when `stby_sel` is 1.
- R7: State 4 exits to state 1 on `irq_evt` or an NMI rising edge. State 5 exits to state 1 only on an NMI rising edge. Interrupts, bus requests and sleep strobes are ignored in state 5.
- R8: In state 3, with no higher-priority event and no `sleep_cmd`, `stby_sel` together with `pause_req` enters state 6 (clock pause). State 6 returns to state 3 when `pause_req` is low.
- R9: `core_clk_en` is 0 in states 5 and 6 and 1 in every other state, sleep included.
- R10: `mod_clk_en[i]` equals the inverse of `mod_stop[i]` sampled at the previous edge, ANDed with `core_clk_en`. Stop bits never change `state_code`.
- R11: An NMI event is a low-to-high change of `nmi_lvl` between two edges outside reset. A level held high does not trigger again. In state 3 an NMI event moves the machine to state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset pin, active low, synchronous |
| nmi_lvl | input | 1 | NMI pin level |
| irq_evt | input | 1 | Enabled interrupt pending |
| dma_err_evt | input | 1 | DMA address-error event |
| exc_done | input | 1 | Exception handling finished |
| bus_req | input | 1 | External bus request level |
| sleep_cmd | input | 1 | SLEEP instruction executed |
| stby_sel | input | 1 | Standby select bit |
| pause_req | input | 1 | Clock-pause request |
| mod_stop | input | N_MOD | Per-module stop bits |
| state_code | output | 3 | Encoded processing state |
| manual_rst | output | 1 | 1 = last reset was manual |
| bus_grant | output | 1 | Bus released to external master |
| core_clk_en | output | 1 | Core clock enable |
| mod_clk_en | output | N_MOD | Per-module clock enables |

## Verification
The bench drives a bus request in the same cycle as an interrupt. A design with the priority reversed would enter exception handling and withhold the grant. It drives bus requests from both exception handling and execution, so a controller that always returns to execution after release is caught. It sends interrupts and sleep strobes into standby, where a loose decoder would wake early. It holds NMI high through and after reset, where a level-sensitive detector would raise a false event. It also toggles stop bits during every state, which catches a module enable that ignores the core clock gate or disturbs the CPU state.

// File: rtl/pstate_pkg.sv
// Shared encoding of the processing states.
package pstate_pkg;
    typedef enum logic [2:0] {
        PS_RESET   = 3'd0,
        PS_EXCEPT  = 3'd1,
        PS_BUSREL  = 3'd2,
        PS_EXEC    = 3'd3,
        PS_SLEEP   = 3'd4,
        PS_STANDBY = 3'd5,
        PS_PAUSE   = 3'd6
    } pstate_t;
endpackage

// File: rtl/pstate_nmi_edge.sv
// Turns the NMI pin level into a one-cycle rising-edge event.
// Assumes nmi_lvl is already synchronous to clk. No event is reported while
// rst_n is low, and the level seen during reset is taken as the baseline.
module pstate_nmi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_lvl,
    output logic nmi_rise
);
    logic nmi_q;

    // Purpose: remember the previous NMI level (also tracked during reset).
    always_ff @(posedge clk) begin
        nmi_q <= nmi_lvl;
    end

    // Purpose: flag a low-to-high change outside reset.
    always_comb begin
        nmi_rise = rst_n & nmi_lvl & ~nmi_q;
    end

    // R11: an event can never occur on two consecutive cycles
    assert_nmi_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_rise |=> !nmi_rise);
endmodule

// File: rtl/pstate_fsm.sv
// Processing-state sequencer. Holds the encoded state, the reset-type flag
// and the return target for a bus release. Assumes all event inputs are
// synchronous and sampled at each rising edge. rst_n is the reset pin and
// has priority over every other input.
module pstate_fsm
    import pstate_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    nmi_lvl,
    input  logic    nmi_rise,
    input  logic    irq_evt,
    input  logic    dma_err_evt,
    input  logic    exc_done,
    input  logic    bus_req,
    input  logic    sleep_cmd,
    input  logic    stby_sel,
    input  logic    pause_req,
    output pstate_t state,
    output logic    manual_rst
);
    pstate_t nxt;
    logic    ret_except;
    logic    exec_event;

    // Purpose: collect the events that start exception handling from execution.
    always_comb begin
        exec_event = irq_evt | dma_err_evt | nmi_rise;
    end

    // Purpose: next-state decode with bus > exception > sleep > pause priority.
    always_comb begin
        nxt = state;
        unique case (state)
            PS_RESET:   nxt = PS_EXCEPT;
            PS_EXCEPT: begin
                if (bus_req)       nxt = PS_BUSREL;
                else if (exc_done) nxt = PS_EXEC;
            end
            PS_BUSREL: begin
                if (!bus_req)      nxt = ret_except ? PS_EXCEPT : PS_EXEC;
            end
            PS_EXEC: begin
                if (bus_req)                  nxt = PS_BUSREL;
                else if (exec_event)          nxt = PS_EXCEPT;
                else if (sleep_cmd)           nxt = stby_sel ? PS_STANDBY : PS_SLEEP;
                else if (stby_sel && pause_req) nxt = PS_PAUSE;
            end
            PS_SLEEP: begin
                if (irq_evt || nmi_rise) nxt = PS_EXCEPT;
            end
            PS_STANDBY: begin
                if (nmi_rise)      nxt = PS_EXCEPT;
            end
            PS_PAUSE: begin
                if (!pause_req)    nxt = PS_EXEC;
            end
            default:               nxt = PS_EXCEPT;
        endcase
    end

    // Purpose: state register, reset-type capture and bus-release return target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= PS_RESET;
            manual_rst <= ~nmi_lvl;
            ret_except <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt == PS_BUSREL && state != PS_BUSREL) begin
                ret_except <= (state == PS_EXCEPT);
            end
        end
    end

    // R3: leaving reset always goes to exception handling
    assert_reset_exit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == PS_RESET |=> state == PS_EXCEPT);

    // R7: only an NMI event leaves standby
    assert_standby_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STANDBY && !nmi_rise) |=> state == PS_STANDBY);

    // R5: a dropped request always ends the bus release
    assert_busrel_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_BUSREL && !bus_req) |=> state != PS_BUSREL);

    // R5: a bus request in execution or exception handling is never overtaken
    assert_bus_priority_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == PS_EXEC || state == PS_EXCEPT) && bus_req) |=> state == PS_BUSREL);
endmodule

// File: rtl/pstate_clkgate.sv
// Per-module clock-enable generator. Each stop bit is registered once and
// gates its module's enable. Every module enable also follows the core clock
// enable, so standby and clock pause stop all peripherals.
module pstate_clkgate #(
    parameter int N_MOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MOD-1:0] mod_stop,
    input  logic             core_clk_en,
    output logic [N_MOD-1:0] mod_clk_en
);
    logic [N_MOD-1:0] stop_q;

    // Purpose: sample the stop bits (data path only, no reset needed).
    always_ff @(posedge clk) begin
        stop_q <= mod_stop;
    end

    for (genvar g = 0; g < N_MOD; g++) begin : g_mod
        // Purpose: enable for one module.
        assign mod_clk_en[g] = ~stop_q[g] & core_clk_en;

        // R10: a set stop bit turns the module's clock off after one edge
        assert_stop_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
            mod_stop[g] |=> !mod_clk_en[g]);
    end
endmodule

// File: rtl/pstate_ctrl.sv
// Top of the processing-state controller. Connects the NMI edge detector,
// the state sequencer and the module clock gating, and decodes grant and
// core clock enable from the state. The reset is synchronous and active low.
module pstate_ctrl
    import pstate_pkg::*;
#(
    parameter int N_MOD = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nmi_lvl,
    input  logic             irq_evt,
    input  logic             dma_err_evt,
    input  logic             exc_done,
    input  logic             bus_req,
    input  logic             sleep_cmd,
    input  logic             stby_sel,
    input  logic             pause_req,
    input  logic [N_MOD-1:0] mod_stop,
    output logic [2:0]       state_code,
    output logic             manual_rst,
    output logic             bus_grant,
    output logic             core_clk_en,
    output logic [N_MOD-1:0] mod_clk_en
);
    pstate_t state;
    logic    nmi_rise;

    pstate_nmi_edge u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_lvl  (nmi_lvl),
        .nmi_rise (nmi_rise)
    );

    pstate_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .nmi_lvl     (nmi_lvl),
        .nmi_rise    (nmi_rise),
        .irq_evt     (irq_evt),
        .dma_err_evt (dma_err_evt),
        .exc_done    (exc_done),
        .bus_req     (bus_req),
        .sleep_cmd   (sleep_cmd),
        .stby_sel    (stby_sel),
        .pause_req   (pause_req),
        .state       (state),
        .manual_rst  (manual_rst)
    );

    // Purpose: decode the externally visible state outputs.
    always_comb begin
        state_code  = state;
        bus_grant   = (state == PS_BUSREL);
        core_clk_en = !(state == PS_STANDBY || state == PS_PAUSE);
    end

    pstate_clkgate #(.N_MOD(N_MOD)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .mod_stop    (mod_stop),
        .core_clk_en (core_clk_en),
        .mod_clk_en  (mod_clk_en)
    );

    // R5: the grant only starts after a request was seen
    assert_grant_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(bus_req));

    // R9: the core clock stays on across a sleep entry
    assert_sleep_clock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == PS_EXEC && state == PS_SLEEP) |-> core_clk_en);
endmodule

// File: tb/pstate_ctrl_bench.sv
module pstate_ctrl_bench;
    localparam int N_MOD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, nmi_lvl = 1'b1, irq_evt = 1'b0, dma_err_evt = 1'b0;
    logic exc_done = 1'b0, bus_req = 1'b0, sleep_cmd = 1'b0, stby_sel = 1'b0, pause_req = 1'b0;
    logic [N_MOD-1:0] mod_stop = '0;
    logic [2:0] state_code;
    logic manual_rst, bus_grant, core_clk_en;
    logic [N_MOD-1:0] mod_clk_en;

    int checks = 0, errors = 0;
    bit checking = 0, done = 0;

    // reference model state
    logic [2:0] m_state = 3'd0;
    logic m_man = 1'b0, m_ret = 1'b0, m_nq = 1'b0;
    logic [N_MOD-1:0] m_stop = '0;
    string m_tag = "R1";

    always #10 clk = ~clk;

    pstate_ctrl #(.N_MOD(N_MOD)) u_pstate_ctrl (
        .clk(clk), .rst_n(rst_n), .nmi_lvl(nmi_lvl), .irq_evt(irq_evt),
        .dma_err_evt(dma_err_evt), .exc_done(exc_done), .bus_req(bus_req),
        .sleep_cmd(sleep_cmd), .stby_sel(stby_sel), .pause_req(pause_req),
        .mod_stop(mod_stop), .state_code(state_code), .manual_rst(manual_rst),
        .bus_grant(bus_grant), .core_clk_en(core_clk_en), .mod_clk_en(mod_clk_en)
    );

    function automatic logic exp_core(input logic [2:0] s);
        return !(s == 3'd5 || s == 3'd6);
    endfunction

    // Reference model, written from the requirements.
    always @(posedge clk) begin
        logic rise;
        rise = nmi_lvl & ~m_nq;
        if (!rst_n) begin
            m_state = 3'd0; m_man = ~nmi_lvl; m_ret = 1'b0; m_tag = "R1";
        end else begin
            case (m_state)
                3'd0: begin m_state = 3'd1; m_tag = "R3"; end
                3'd1: begin
                    m_tag = "R4";
                    if (bus_req) begin m_state = 3'd2; m_ret = 1'b1; m_tag = "R5"; end
                    else if (exc_done) m_state = 3'd3;
                end
                3'd2: begin
                    m_tag = "R5";
                    if (!bus_req) m_state = m_ret ? 3'd1 : 3'd3;
                end
                3'd3: begin
                    m_tag = "R4";
                    if (bus_req) begin m_state = 3'd2; m_ret = 1'b0; m_tag = "R5"; end
                    else if (irq_evt || dma_err_evt) m_state = 3'd1;
                    else if (rise) begin m_state = 3'd1; m_tag = "R11"; end
                    else if (sleep_cmd) begin m_state = stby_sel ? 3'd5 : 3'd4; m_tag = "R6"; end
                    else if (stby_sel && pause_req) begin m_state = 3'd6; m_tag = "R8"; end
                end
                3'd4: begin m_tag = "R7"; if (irq_evt || rise) m_state = 3'd1; end
                3'd5: begin m_tag = "R7"; if (rise) m_state = 3'd1; end
                default: begin m_tag = "R8"; if (!pause_req) m_state = 3'd3; end
            endcase
        end
        m_nq = nmi_lvl;
        m_stop = mod_stop;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare all outputs away from the active edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            chk(m_tag, {5'd0, state_code}, {5'd0, m_state}, "state_code");
            chk("R2", {7'd0, manual_rst}, {7'd0, m_man}, "manual_rst");
            chk("R5", {7'd0, bus_grant}, {7'd0, (m_state == 3'd2)}, "bus_grant");
            chk("R9", {7'd0, core_clk_en}, {7'd0, exp_core(m_state)}, "core_clk_en");
            chk("R10", {4'd0, mod_clk_en}, {4'd0, ~m_stop & {N_MOD{exp_core(m_state)}}}, "mod_clk_en");
        end
    end

    task automatic quiet();
        irq_evt = 0; dma_err_evt = 0; exc_done = 0; sleep_cmd = 0;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1 R2: power-on reset with NMI high
        nmi_lvl = 1; rst_n = 0;
        step(3);
        checking = 1;
        step(1);
        rst_n = 1;                 // R3: exit to exception handling
        step(2);
        // R5: bus request from exception handling, same cycle as done
        bus_req = 1; exc_done = 1; step(1); quiet(); step(2);
        bus_req = 0; step(1);      // returns to exception handling
        exc_done = 1; step(1); quiet(); step(1);
        // R5: bus request beats a same-cycle interrupt in execution
        bus_req = 1; irq_evt = 1; step(1); quiet(); step(1);
        bus_req = 0; step(2);
        // R6 R7: standby ignores interrupt and bus request, NMI wakes it (R11)
        nmi_lvl = 0; stby_sel = 1; sleep_cmd = 1; step(1); quiet();
        irq_evt = 1; bus_req = 1; step(1); quiet(); bus_req = 0; step(2);
        nmi_lvl = 1; step(1); step(2);
        exc_done = 1; step(1); quiet(); step(2);   // NMI still high: no re-trigger
        // R6 R7: sleep, woken by interrupt
        stby_sel = 0; sleep_cmd = 1; step(1); quiet(); step(2);
        irq_evt = 1; step(1); quiet(); exc_done = 1; step(1); quiet();
        // R8: clock pause
        stby_sel = 1; pause_req = 1; step(3); pause_req = 0; step(2); stby_sel = 0;
        // R10: module stop bits during execution
        mod_stop = 4'b1010; step(2); mod_stop = 4'b0001; step(2); mod_stop = 0;
        // R2: manual reset with NMI low
        nmi_lvl = 0; rst_n = 0; step(2); rst_n = 1; step(2);

        // Constrained random phase
        for (int i = 0; i < 4000; i++) begin
            rst_n       = ($urandom_range(0, 99) != 0);
            if ($urandom_range(0, 15) == 0) nmi_lvl = ~nmi_lvl;
            irq_evt     = ($urandom_range(0, 9) == 0);
            dma_err_evt = ($urandom_range(0, 29) == 0);
            exc_done    = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 11) == 0) bus_req = ~bus_req;
            sleep_cmd   = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 7) == 0) stby_sel = ~stby_sel;
            if ($urandom_range(0, 5) == 0) pause_req = ~pause_req;
            if ($urandom_range(0, 7) == 0) mod_stop = N_MOD'($urandom);
            step(1);
        end
        step(1);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule